// File: doc/BRIEF.md
# Signed Long-by-Short Divide Unit with Legacy Timing

This block divides a 32-bit two's-complement dividend by a 16-bit two's-complement divisor and returns one packed 32-bit word. The upper half holds the 16-bit remainder and the lower half holds the 16-bit quotient. It also produces overflow, negative, zero and carry condition flags. An instruction sequencer uses it to mimic an older processor's divide instruction. The number of clock cycles taken depends on the data and follows that processor's microcode timing. The unit reports the cost on `cycles` and raises `done` in exactly the cycle that the cost names.

The sequencer presents the current destination register value on `dividend` and the source operand on `divisor`, then pulses `start` while the unit is not busy. The unit takes the magnitudes of both operands. It first decides whether the magnitude quotient fits in 15 bits. If it does, a restoring divider produces the quotient and remainder, and the unit applies the signs afterwards. The unit then waits until the computed cycle count has elapsed. A divisor of zero is flagged on `div_zero` and nothing else changes.

Top module: `sdiv_timed_unit`

## Requirements
- R1: For a non-zero divisor without overflow, `result[15:0]` is the truncated signed quotient and `result[31:16]` is the remainder, so that dividend = quotient × divisor + remainder.
- R2: The quotient is negative exactly when the operand signs differ, and a non-zero remainder has the sign of the dividend.
- R3: `ovf_flag` is set exactly when the magnitude quotient |dividend| / |divisor| is above 32767. A negative true quotient of -32768 therefore counts as overflow.
- R4: On overflow, `result` holds the dividend unchanged, `zero_flag` is set when bits 15:0 of |dividend| are zero, `neg_flag` equals bit 15 of |dividend|, and the operation costs exactly 12 cycles.
- R5: Without overflow, `ovf_flag` is 0, `neg_flag` is bit 15 of the signed quotient, and `zero_flag` is 1 exactly when the 16-bit quotient is zero.
- R6: The cost of an operation without overflow starts from 12 cycles. A negative dividend adds 2, and loop overhead adds a fixed 104.
- R7: The cost of an operation without overflow also includes 2 cycles for every zero bit among bits 15 down to 1 of the magnitude quotient. Bit 0 is not counted.
- R8: At the end of an operation without overflow, a negative divisor adds 2 cycles. Otherwise a negative dividend adds 4 cycles.
- R9: If `start` is accepted at clock edge E, then `done` is high for one cycle after edge E+N-1, where N is the value then shown on `cycles`. `busy` is high between acceptance and `done`, and it is low while `done` is high.
- R10: A zero divisor raises `div_zero` and `done` together after the accepting edge, with `cycles` = 1. `result` and all four flags keep their previous values.
- R11: `start` is ignored while `busy` is high. `result`, the flags and `cycles` change only when `done` is raised.
- R12: After reset, `busy`, `done`, `div_zero`, `result`, all flags and `cycles` are zero.
- R13: `carry_flag` is 0 after every completed operation that has a non-zero divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a divide; accepted when `busy` is low |
| dividend | input | 32 | Two's-complement dividend (current destination value) |
| divisor | input | 16 | Two's-complement divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Pulses with `done` when the divisor was zero |
| result | output | 32 | Remainder in bits 31:16, quotient in bits 15:0 |
| ovf_flag | output | 1 | Overflow flag |
| neg_flag | output | 1 | Negative flag |
| zero_flag | output | 1 | Zero flag |
| carry_flag | output | 1 | Carry flag, always cleared on completion |
| cycles | output | 8 | Cycle cost of the last completed operation |

## Verification
The bound assertions check the following on every cycle:
- The completion edge lines up with the reported cost, counted from the acceptance edge.
- `done` and `busy` are never high together.
- An overflow always costs 12 cycles.
- The negative and zero flags agree with the quotient half of the result.
- An operation without overflow has a cost within its legal range.
- A zero-divisor completion leaves the result and flags untouched.
- The outputs stay stable while the unit is busy.

The assertions cannot show that the quotient, remainder and exact cycle count are arithmetically right for given operands. The bench's operand sweeps show this instead: a grid of boundary dividends and divisors (the most negative dividend, ±1, the ±32768 quotient edges, mixed signs), plus scaled pseudo-random operands, all compared with arithmetic done in the bench.

// File: rtl/sdiv_pkg.sv
// Shared types for the timed signed divide unit.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package sdiv_pkg;

    // Control sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_WAIT   = 2'd2
    } sdiv_state_e;

    // Condition flag group written at completion
    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } sdiv_flags_t;

endpackage

// File: rtl/sdiv_operand_prep.sv
// Operand preparation: takes the magnitudes and signs of both operands,
// detects a zero divisor, and decides overflow before any division.
// Assumes DD_W = 2*DS_W so the quotient width equals the divisor width.
// Overflow means the magnitude quotient needs more than QW-1 bits.
module sdiv_operand_prep #(
    parameter int DD_W = 32,
    parameter int DS_W = 16
) (
    input  logic [DD_W-1:0] dividend,
    input  logic [DS_W-1:0] divisor,
    output logic [DD_W-1:0] dd_mag,
    output logic [DS_W-1:0] ds_mag,
    output logic            dd_neg,
    output logic            ds_neg,
    output logic            ds_zero,
    output logic            ovf
);
    localparam int QW = DD_W - DS_W;

    logic [DD_W-1:0] dd_hi;

    // Sign extraction and two's-complement magnitude of each operand
    always_comb begin
        dd_neg = dividend[DD_W-1];
        ds_neg = divisor[DS_W-1];
        dd_mag = dd_neg ? (~dividend + 1'b1) : dividend;
        ds_mag = ds_neg ? (~divisor + 1'b1) : divisor;
        ds_zero = (divisor == '0);
    end

    // Quotient >= 2^(QW-1) exactly when floor(|dd| / 2^(QW-1)) >= |ds|
    always_comb begin
        dd_hi = dd_mag >> (QW - 1);
        ovf = (dd_hi >= {{QW{1'b0}}, ds_mag});
    end

endmodule

// File: rtl/sdiv_restore_core.sv
// Unsigned restoring divider, one quotient bit per clock.
// Assumes the magnitude quotient fits in QW bits, so the upper DS_W bits of
// the dividend are already smaller than the divisor (overflow excluded).
// Loads on 'load', then runs QW steps; 'last' marks the final step.
module sdiv_restore_core #(
    parameter int DD_W = 32,
    parameter int DS_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [DD_W-1:0]       dd_mag,
    input  logic [DS_W-1:0]       ds_mag,
    output logic [DD_W-DS_W-1:0]  quo,
    output logic [DS_W-1:0]       rem,
    output logic                  last
);
    localparam int QW = DD_W - DS_W;
    localparam int SW = $clog2(QW + 1);

    logic [SW-1:0]   steps_q;
    logic [DS_W-1:0] rem_q;
    logic [QW-1:0]   sh_q;
    logic [DS_W:0]   trial;
    logic [DS_W:0]   diff;
    logic            fits;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        trial = {rem_q, sh_q[QW-1]};
        diff  = trial - {1'b0, ds_mag};
        fits  = (trial >= {1'b0, ds_mag});
    end

    // Load operands or perform one restoring step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_q <= '0;
            rem_q   <= '0;
            sh_q    <= '0;
        end else if (load) begin
            steps_q <= SW'(QW);
            rem_q   <= dd_mag[DD_W-1:QW];
            sh_q    <= dd_mag[QW-1:0];
        end else if (steps_q != '0) begin
            steps_q <= steps_q - 1'b1;
            rem_q   <= fits ? diff[DS_W-1:0] : trial[DS_W-1:0];
            sh_q    <= {sh_q[QW-2:0], fits};
        end
    end

    assign quo  = sh_q;
    assign rem  = rem_q;
    assign last = (steps_q == SW'(1));

endmodule

// File: rtl/sdiv_cycle_cost.sv
// Cycle cost model of the legacy signed divide.
// Assumes 'quo' is the settled magnitude quotient (ignored on overflow).
// Counts zero bits QW-1..1 of the quotient; bit 0 never contributes.
module sdiv_cycle_cost #(
    parameter int QW            = 16,
    parameter int CNT_W         = 8,
    parameter int BASE_CYC      = 12,
    parameter int NEG_DD_CYC    = 2,
    parameter int ZERO_BIT_CYC  = 2,
    parameter int LOOP_CYC      = 104,
    parameter int NEG_DS_TAIL   = 2,
    parameter int NEG_DD_TAIL   = 4,
    parameter int OVF_CYC       = 12
) (
    input  logic [QW-1:0]    quo,
    input  logic             dd_neg,
    input  logic             ds_neg,
    input  logic             ovf,
    output logic [CNT_W-1:0] cost
);
    logic [QW-1:1]    zero_bits;
    logic [CNT_W-1:0] zero_cnt;
    logic [CNT_W-1:0] head;
    logic [CNT_W-1:0] tail;

    // One zero-detect cell per counted quotient bit
    for (genvar g = 1; g < QW; g++) begin : g_zero
        assign zero_bits[g] = ~quo[g];
    end

    // Population count of the zero bits
    always_comb begin
        zero_cnt = '0;
        for (int i = 1; i < QW; i++) begin
            zero_cnt = zero_cnt + {{(CNT_W-1){1'b0}}, zero_bits[i]};
        end
    end

    // Sign-dependent entry and exit charges
    always_comb begin
        head = dd_neg ? CNT_W'(BASE_CYC + NEG_DD_CYC) : CNT_W'(BASE_CYC);
        if (ds_neg) begin
            tail = CNT_W'(NEG_DS_TAIL);
        end else if (dd_neg) begin
            tail = CNT_W'(NEG_DD_TAIL);
        end else begin
            tail = '0;
        end
    end

    // Total cost; overflow takes a fixed exit
    always_comb begin
        if (ovf) begin
            cost = CNT_W'(OVF_CYC);
        end else begin
            cost = head + zero_cnt * CNT_W'(ZERO_BIT_CYC) + CNT_W'(LOOP_CYC) + tail;
        end
    end

endmodule

// File: rtl/sdiv_timed_unit.sv
// Timed signed divide unit: DD_W-bit dividend by DS_W-bit divisor, packed
// remainder:quotient result, V/N/Z/C flags, and a completion pulse placed
// at the data-dependent legacy cycle cost.
// Assumes start is only honoured while idle; results hold between operations.
module sdiv_timed_unit
    import sdiv_pkg::*;
#(
    parameter int DD_W          = 32,
    parameter int DS_W          = 16,
    parameter int CNT_W         = 8,
    parameter int BASE_CYC      = 12,
    parameter int NEG_DD_CYC    = 2,
    parameter int ZERO_BIT_CYC  = 2,
    parameter int LOOP_CYC      = 104,
    parameter int NEG_DS_TAIL   = 2,
    parameter int NEG_DD_TAIL   = 4,
    parameter int OVF_CYC       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DD_W-1:0]  dividend,
    input  logic [DS_W-1:0]  divisor,
    output logic             busy,
    output logic             done,
    output logic             div_zero,
    output logic [DD_W-1:0]  result,
    output logic             ovf_flag,
    output logic             neg_flag,
    output logic             zero_flag,
    output logic             carry_flag,
    output logic [CNT_W-1:0] cycles
);
    localparam int QW = DD_W - DS_W;

    sdiv_state_e      state_q;
    logic [CNT_W-1:0] elapsed_q;
    logic [DD_W-1:0]  dd_q;
    logic [QW-1:0]    dd_mag_lo_q;
    logic [DS_W-1:0]  ds_mag_q;
    logic             dd_neg_q;
    logic             ds_neg_q;
    logic             ovf_q;

    logic [DD_W-1:0]  p_dd_mag;
    logic [DS_W-1:0]  p_ds_mag;
    logic             p_dd_neg;
    logic             p_ds_neg;
    logic             p_ds_zero;
    logic             p_ovf;

    logic [QW-1:0]    core_quo;
    logic [DS_W-1:0]  core_rem;
    logic             core_last;
    logic [CNT_W-1:0] cost;

    logic             accept;
    logic             finish;
    logic [QW-1:0]    q_signed;
    logic [DS_W-1:0]  r_signed;

    logic [DD_W-1:0]  result_q;
    sdiv_flags_t      flags_q;
    logic [CNT_W-1:0] cycles_q;
    logic             done_q;
    logic             dz_q;

    sdiv_operand_prep #(
        .DD_W (DD_W),
        .DS_W (DS_W)
    ) u_prep (
        .dividend (dividend),
        .divisor  (divisor),
        .dd_mag   (p_dd_mag),
        .ds_mag   (p_ds_mag),
        .dd_neg   (p_dd_neg),
        .ds_neg   (p_ds_neg),
        .ds_zero  (p_ds_zero),
        .ovf      (p_ovf)
    );

    sdiv_restore_core #(
        .DD_W (DD_W),
        .DS_W (DS_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept && !p_ds_zero && !p_ovf),
        .dd_mag (p_dd_mag),
        .ds_mag (ds_mag_q),
        .quo    (core_quo),
        .rem    (core_rem),
        .last   (core_last)
    );

    sdiv_cycle_cost #(
        .QW           (QW),
        .CNT_W        (CNT_W),
        .BASE_CYC     (BASE_CYC),
        .NEG_DD_CYC   (NEG_DD_CYC),
        .ZERO_BIT_CYC (ZERO_BIT_CYC),
        .LOOP_CYC     (LOOP_CYC),
        .NEG_DS_TAIL  (NEG_DS_TAIL),
        .NEG_DD_TAIL  (NEG_DD_TAIL),
        .OVF_CYC      (OVF_CYC)
    ) u_cost (
        .quo    (core_quo),
        .dd_neg (dd_neg_q),
        .ds_neg (ds_neg_q),
        .ovf    (ovf_q),
        .cost   (cost)
    );

    // Handshake decode: accept when idle, finish when the cost has elapsed
    always_comb begin
        accept = start && (state_q == ST_IDLE);
        finish = (state_q == ST_WAIT) && (elapsed_q == cost - CNT_W'(1));
    end

    // Apply signs after the unsigned divide: quotient by sign difference,
    // remainder by dividend sign
    always_comb begin
        q_signed = (dd_neg_q ^ ds_neg_q) ? (~core_quo + 1'b1) : core_quo;
        r_signed = dd_neg_q ? (~core_rem + 1'b1) : core_rem;
    end

    // Sequencer: idle -> divide -> wait, with an elapsed-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            elapsed_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        elapsed_q <= CNT_W'(1);
                        if (p_ds_zero) begin
                            state_q <= ST_IDLE;
                        end else if (p_ovf) begin
                            state_q <= ST_WAIT;
                        end else begin
                            state_q <= ST_DIVIDE;
                        end
                    end
                end
                ST_DIVIDE: begin
                    elapsed_q <= elapsed_q + 1'b1;
                    if (core_last) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    elapsed_q <= elapsed_q + 1'b1;
                    if (finish) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Capture operand attributes at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dd_q        <= '0;
            dd_mag_lo_q <= '0;
            ds_mag_q    <= '0;
            dd_neg_q    <= 1'b0;
            ds_neg_q    <= 1'b0;
            ovf_q       <= 1'b0;
        end else if (accept) begin
            dd_q        <= dividend;
            dd_mag_lo_q <= p_dd_mag[QW-1:0];
            ds_mag_q    <= p_ds_mag;
            dd_neg_q    <= p_dd_neg;
            ds_neg_q    <= p_ds_neg;
            ovf_q       <= p_ovf && !p_ds_zero;
        end
    end

    // Completion: write result, flags, cost and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
            cycles_q <= '0;
            done_q   <= 1'b0;
            dz_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            dz_q   <= 1'b0;
            if (accept && p_ds_zero) begin
                done_q   <= 1'b1;
                dz_q     <= 1'b1;
                cycles_q <= CNT_W'(1);
            end else if (finish) begin
                done_q   <= 1'b1;
                cycles_q <= cost;
                if (ovf_q) begin
                    result_q <= dd_q;
                    flags_q  <= '{v: 1'b1, n: dd_mag_lo_q[QW-1],
                                  z: (dd_mag_lo_q == '0), c: 1'b0};
                end else begin
                    result_q <= {r_signed, q_signed};
                    flags_q  <= '{v: 1'b0, n: q_signed[QW-1],
                                  z: (q_signed == '0), c: 1'b0};
                end
            end
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign div_zero   = dz_q;
    assign result     = result_q;
    assign ovf_flag   = flags_q.v;
    assign neg_flag   = flags_q.n;
    assign zero_flag  = flags_q.z;
    assign carry_flag = flags_q.c;
    assign cycles     = cycles_q;

endmodule

// File: rtl/sdiv_timed_unit_chk.sv
// Port-level checker for the timed signed divide unit.
// Keeps its own latency counter from acceptance to completion.
module sdiv_timed_unit_chk #(
    parameter int DD_W          = 32,
    parameter int DS_W          = 16,
    parameter int CNT_W         = 8,
    parameter int BASE_CYC      = 12,
    parameter int NEG_DD_CYC    = 2,
    parameter int ZERO_BIT_CYC  = 2,
    parameter int LOOP_CYC      = 104,
    parameter int NEG_DS_TAIL   = 2,
    parameter int NEG_DD_TAIL   = 4,
    parameter int OVF_CYC       = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             div_zero,
    input logic [DD_W-1:0]  result,
    input logic             ovf_flag,
    input logic             neg_flag,
    input logic             zero_flag,
    input logic             carry_flag,
    input logic [CNT_W-1:0] cycles
);
    localparam int QW       = DD_W - DS_W;
    localparam int TAIL_MAX = (NEG_DS_TAIL > NEG_DD_TAIL) ? NEG_DS_TAIL : NEG_DD_TAIL;
    localparam int MIN_CYC  = BASE_CYC + LOOP_CYC + ZERO_BIT_CYC;
    localparam int MAX_CYC  = BASE_CYC + NEG_DD_CYC + ZERO_BIT_CYC * (QW - 1) + LOOP_CYC + TAIL_MAX;

    logic [CNT_W-1:0] lat_cnt;

    // Count cycles from the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (start && !busy) begin
            lat_cnt <= CNT_W'(1);
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == cycles));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    overflow_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && ovf_flag) |-> (cycles == CNT_W'(OVF_CYC)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !ovf_flag) |->
            ((zero_flag == (result[QW-1:0] == '0)) && (neg_flag == result[QW-1])));

    // R8
    cost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !ovf_flag) |->
            ((cycles >= CNT_W'(MIN_CYC)) && (cycles <= CNT_W'(MAX_CYC))));

    // R10
    divzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (done && (cycles == CNT_W'(1)) && $stable(result) &&
                      $stable(ovf_flag) && $stable(neg_flag) &&
                      $stable(zero_flag) && $stable(carry_flag)));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(result) && $stable(cycles) && $stable(ovf_flag)));

    // R13
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> !carry_flag);

endmodule

bind sdiv_timed_unit sdiv_timed_unit_chk #(
    .DD_W         (DD_W),
    .DS_W         (DS_W),
    .CNT_W        (CNT_W),
    .BASE_CYC     (BASE_CYC),
    .NEG_DD_CYC   (NEG_DD_CYC),
    .ZERO_BIT_CYC (ZERO_BIT_CYC),
    .LOOP_CYC     (LOOP_CYC),
    .NEG_DS_TAIL  (NEG_DS_TAIL),
    .NEG_DD_TAIL  (NEG_DD_TAIL),
    .OVF_CYC      (OVF_CYC)
) u_sdiv_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .div_zero   (div_zero),
    .result     (result),
    .ovf_flag   (ovf_flag),
    .neg_flag   (neg_flag),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag),
    .cycles     (cycles)
);

// File: tb/sdiv_timed_unit_test.sv
// Bench for the timed signed divide unit: operand grid sweep plus scaled
// pseudo-random operands, expected values from integer arithmetic.
module sdiv_timed_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, div_zero;
    logic [31:0] result;
    logic        ovf_flag, neg_flag, zero_flag, carry_flag;
    logic [7:0]  cycles;

    int checks = 0;
    int errors = 0;

    // expected values and last architectural state
    logic [31:0] exp_res;
    logic        exp_v, exp_n, exp_z, exp_dz;
    int          exp_cyc;
    logic [31:0] prev_res = '0;
    logic        prev_v = 0, prev_n = 0, prev_z = 0;

    always #10 clk = ~clk;   // 50 MHz

    sdiv_timed_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .div_zero(div_zero), .result(result),
        .ovf_flag(ovf_flag), .neg_flag(neg_flag), .zero_flag(zero_flag),
        .carry_flag(carry_flag), .cycles(cycles)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Arithmetic model of one operation
    task automatic model(input logic [31:0] dd, input logic [15:0] ds);
        longint sdd, sds, mdd, mds, q, qs, r;
        int zeros;
        sdd = longint'($signed(dd));
        sds = longint'($signed(ds));
        if (ds == 16'd0) begin
            exp_dz = 1; exp_res = prev_res;
            exp_v = prev_v; exp_n = prev_n; exp_z = prev_z; exp_cyc = 1;
            return;
        end
        exp_dz = 0;
        mdd = (sdd < 0) ? -sdd : sdd;
        mds = (sds < 0) ? -sds : sds;
        q = mdd / mds;
        if (q > 32767) begin
            exp_res = dd; exp_v = 1;
            exp_z = (mdd[15:0] == 16'd0); exp_n = mdd[15]; exp_cyc = 12;
        end else begin
            qs = ((sdd < 0) != (sds < 0)) ? -q : q;
            r = sdd - qs * sds;
            exp_res = {r[15:0], qs[15:0]};
            exp_v = 0; exp_n = qs[15]; exp_z = (qs[15:0] == 16'd0);
            zeros = 0;
            for (int i = 1; i < 16; i++) if (!q[i]) zeros++;
            exp_cyc = 12 + ((sdd < 0) ? 2 : 0) + 2 * zeros + 104;
            if (sds < 0) exp_cyc += 2;
            else if (sdd < 0) exp_cyc += 4;
        end
    endtask

    // Issue one operation, measure latency in edges, check every output
    task automatic run_op(input logic [31:0] dd, input logic [15:0] ds, input bit poke);
        int n;
        string t;
        model(dd, ds);
        dividend = dd; divisor = ds; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n = 1;
        while (!done && n < 400) begin
            if (poke && n == 5) begin
                dividend = 32'h0000_0001; divisor = 16'h0003; start = 1'b1;
            end
            @(posedge clk); #1;
            start = 1'b0;
            n++;
        end
        if (exp_dz) t = "R10";
        else if (exp_v) t = "R4";
        else t = "R1 R2";
        if (poke) t = {t, " R11"};
        chk(result == exp_res, t, result, exp_res);
        chk(ovf_flag == exp_v, {t, " R3"}, ovf_flag, exp_v);
        chk({neg_flag, zero_flag} == {exp_n, exp_z}, exp_v ? t : {t, " R5"},
            {neg_flag, zero_flag}, {exp_n, exp_z});
        chk(div_zero == exp_dz, {t, " R10"}, div_zero, exp_dz);
        if (!exp_dz) chk(carry_flag == 1'b0, "R13", carry_flag, 0);
        chk(n == exp_cyc, "R6 R7 R8 R9 latency", n, exp_cyc);
        chk(int'(cycles) == exp_cyc, "R6 R7 R8 R9 cycles", cycles, exp_cyc);
        prev_res = exp_res; prev_v = exp_v; prev_n = exp_n; prev_z = exp_z;
        @(posedge clk); #1;
        chk(done == 1'b0 && busy == 1'b0, "R9 pulse", {done, busy}, 0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [31:0] dd_set [16];
    logic [15:0] ds_set [11];

    initial begin
        dd_set = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd7, -32'sd7, 32'd100, -32'sd100,
                   32'd32767, -32'sd32767, 32'd32768, -32'sd32768, 32'd65535,
                   32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_0000, 32'd123456};
        ds_set = '{16'd1, 16'hFFFF, 16'd2, 16'hFFFE, 16'd7, 16'hFFF9,
                   16'h7FFF, 16'h8000, 16'd255, 16'hFF01, 16'd0};
        repeat (4) @(posedge clk);
        #1;
        // R12 reset state
        chk({busy, done, div_zero} == 3'b000, "R12 ctrl", {busy, done, div_zero}, 0);
        chk(result == 32'd0, "R12 result", result, 0);
        chk({ovf_flag, neg_flag, zero_flag, carry_flag} == 4'd0, "R12 flags",
            {ovf_flag, neg_flag, zero_flag, carry_flag}, 0);
        chk(cycles == 8'd0, "R12 cycles", cycles, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // boundary grid sweep
        foreach (dd_set[i]) foreach (ds_set[j]) run_op(dd_set[i], ds_set[j], 1'b0);

        // R11 start ignored while busy
        run_op(32'd1000, 16'd3, 1'b1);
        run_op(-32'sd50000, 16'h8000, 1'b1);

        // scaled pseudo-random operands with mixed signs
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a;
            logic [15:0] b;
            a = $urandom >> ($urandom % 32);
            b = 16'($urandom >> ($urandom % 32));
            if ($urandom % 2) a = -a;
            if ($urandom % 2) b = -b;
            run_op(a, b, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule